// File: doc/BRIEF.md
# Private-Bank DRAM Command Sequencer

This block sits between one requestor and that requestor's command queue in a predictable DRAM controller where every requestor owns a bank of its own. It takes read and write requests that carry a row and a column address. It remembers which row, if any, is held in the bank's row buffer. Each request is turned into the shortest legal command series. A row-buffer hit needs only the column access. A miss with a row already open needs a precharge, then an activate, then the access. A miss on an empty bank needs an activate and then the access.

Commands leave through a valid/ready port toward the per-requestor queue. Every command carries a type code, the bank index, an address and the requestor identity. The bank belongs to one requestor only, so its open-row record can change only through this block's own commands. The `OPEN_ROW` parameter picks the row policy. When set, an accessed row is kept open. When clear, every access is treated as ending in an implicit precharge, so each request costs an activate plus the access. A per-request hit flag lets a bench or monitor tally row hits and misses.

Top module: `dram_cmd_gen`

## Requirements
- R1: After synchronous reset, cmd_valid and hit_valid are 0, req_ready is 1, and the bank holds no open row.
- R2: A request to a bank with no open row emits ACT carrying the row, then the access carrying the column, and no precharge. Its hit flag is 0.
- R3: Under the open-row policy, a request whose row equals the open row emits only the access command, and its hit flag is 1.
- R4: A request to a row other than the open one emits PRE (address field = row being closed), then ACT (new row), then the access, in that order. Its hit flag is 0.
- R5: Under the open-row policy, the accessed row stays open after its access completes, so the next request to that row is a hit.
- R6: Under the close-row policy (OPEN_ROW=0), every request emits ACT then the access, never PRE, and its hit flag is always 0.
- R7: cmd_type encodes 2'b00 PRE, 2'b01 ACT, 2'b10 RD, 2'b11 WR. cmd_bank equals BANK_ID and cmd_rid equals REQ_ID. cmd_addr holds the row (ACT/PRE) or the column (RD/WR), zero-extended.
- R8: req_ready is 0 from the cycle after a request is accepted until the cycle after its last command is taken. While cmd_valid is 1 and cmd_ready is 0, the command fields hold still.
- R9: hit_valid pulses for exactly one cycle, in the cycle after acceptance, with hit giving the hit/miss result of that request.
- R10: req_write=1 selects WR as the access command and req_write=0 selects RD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command queue takes the command |
| cmd_type | output | 2 | Command code |
| cmd_bank | output | BANK_W | Bank index |
| cmd_addr | output | ADDR_W | Row or column address |
| cmd_rid | output | RID_W | Requestor identity |
| hit_valid | output | 1 | Hit flag valid for one cycle |
| hit | output | 1 | Request was a row-buffer hit |

## Verification
A request accepted at a clock edge shows its first command and its hit_valid pulse in the cycle after that edge. Each later command appears in the cycle after the edge where the previous one was taken. req_ready returns one cycle after the final command is taken. The bench drives inputs on falling edges and checks outputs on the falling edge that follows each rising edge, so every value is read one register stage after its cause. One scenario holds cmd_ready low for a cycle and checks that the pending command has not changed on the next falling edge.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;
  typedef enum logic [1:0] {
    CMD_PRE = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_WR  = 2'b11
  } cmd_kind_e;
endpackage

// File: rtl/dram_open_row.sv
// Open-row record for the private bank.
module dram_open_row #(
  parameter int ROW_W    = 14,
  parameter bit OPEN_ROW = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [ROW_W-1:0] upd_row,
  output logic             open_vld,
  output logic [ROW_W-1:0] open_row
);
  always_ff @(posedge clk) begin
    if (rst) begin
      open_vld <= 1'b0;
      open_row <= '0;
    end else if (upd) begin
      open_vld <= OPEN_ROW;
      open_row <= upd_row;
    end
  end
endmodule

// File: rtl/dram_cmd_seq.sv
// Expands one request into its command series.
module dram_cmd_seq
  import dram_cmd_pkg::*;
#(
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  parameter int ADDR_W   = 14,
  parameter bit OPEN_ROW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              open_vld,
  input  logic [ROW_W-1:0]  open_row,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output cmd_kind_e         cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              hit_valid,
  output logic              hit,
  output logic              done,
  output logic [ROW_W-1:0]  done_row
);
  logic             lat_write;
  logic [ROW_W-1:0] lat_row;
  logic [COL_W-1:0] lat_col;
  logic             accept, take, row_hit;
  cmd_kind_e        acc_kind, req_acc;

  assign req_ready = !cmd_valid;
  assign accept    = req_valid && req_ready;
  assign take      = cmd_valid && cmd_ready;
  assign row_hit   = OPEN_ROW && open_vld && (open_row == req_row);
  assign acc_kind  = lat_write ? CMD_WR : CMD_RD;
  assign req_acc   = req_write ? CMD_WR : CMD_RD;
  assign done      = take && cmd_kind[1];
  assign done_row  = lat_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_kind  <= CMD_PRE;
      cmd_addr  <= '0;
      hit_valid <= 1'b0;
      hit       <= 1'b0;
      lat_write <= 1'b0;
      lat_row   <= '0;
      lat_col   <= '0;
    end else begin
      hit_valid <= accept;
      if (accept) begin
        lat_write <= req_write;
        lat_row   <= req_row;
        lat_col   <= req_col;
        hit       <= row_hit;
        cmd_valid <= 1'b1;
        if (row_hit) begin
          cmd_kind <= req_acc;
          cmd_addr <= ADDR_W'(req_col);
        end else if (open_vld) begin
          cmd_kind <= CMD_PRE;
          cmd_addr <= ADDR_W'(open_row);
        end else begin
          cmd_kind <= CMD_ACT;
          cmd_addr <= ADDR_W'(req_row);
        end
      end else if (take) begin
        case (cmd_kind)
          CMD_PRE: begin
            cmd_kind <= CMD_ACT;
            cmd_addr <= ADDR_W'(lat_row);
          end
          CMD_ACT: begin
            cmd_kind <= acc_kind;
            cmd_addr <= ADDR_W'(lat_col);
          end
          default: cmd_valid <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dram_cmd_gen.sv
module dram_cmd_gen #(
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  parameter int BANK_W   = 3,
  parameter int RID_W    = 2,
  parameter int BANK_ID  = 0,
  parameter int REQ_ID   = 0,
  parameter bit OPEN_ROW = 1'b1,
  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_type,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [RID_W-1:0]  cmd_rid,
  output logic              hit_valid,
  output logic              hit
);
  import dram_cmd_pkg::*;

  logic             open_vld, done;
  logic [ROW_W-1:0] open_row, done_row;
  cmd_kind_e        kind;

  dram_open_row #(.ROW_W(ROW_W), .OPEN_ROW(OPEN_ROW)) row_i (
    .clk(clk), .rst(rst), .upd(done), .upd_row(done_row),
    .open_vld(open_vld), .open_row(open_row)
  );

  dram_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
                 .OPEN_ROW(OPEN_ROW)) seq_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_row(req_row), .req_col(req_col),
    .open_vld(open_vld), .open_row(open_row),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(kind),
    .cmd_addr(cmd_addr), .hit_valid(hit_valid), .hit(hit),
    .done(done), .done_row(done_row)
  );

  assign cmd_type = kind;
  assign cmd_bank = BANK_W'(BANK_ID);
  assign cmd_rid  = RID_W'(REQ_ID);
endmodule

// File: rtl/dram_cmd_gen_chk.sv
module dram_cmd_gen_chk #(
  parameter int ADDR_W   = 14,
  parameter bit OPEN_ROW = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_type,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              hit_valid,
  input logic              hit
);
  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_type) && $stable(cmd_addr));
  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !req_ready);
  // R4
  pre_then_act_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_type == 2'b00 |=> cmd_valid && cmd_type == 2'b01);
  // R2
  act_then_access_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_type == 2'b01 |=> cmd_valid && cmd_type[1]);
  // R8
  access_ends_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_type[1] |=> !cmd_valid && req_ready);
  // R9
  accept_flag_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> hit_valid && cmd_valid);
  // R9
  flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    hit_valid |=> !hit_valid);
  // R3
  hit_direct_chk: assert property (@(posedge clk) disable iff (rst)
    hit_valid && hit |-> cmd_type[1]);
  generate
    if (!OPEN_ROW) begin : g_close
      // R6
      no_pre_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_type != 2'b00 && !(hit_valid && hit));
    end
  endgenerate
endmodule

bind dram_cmd_gen dram_cmd_gen_chk #(.ADDR_W(ADDR_W), .OPEN_ROW(OPEN_ROW)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_type(cmd_type),
  .cmd_addr(cmd_addr), .hit_valid(hit_valid), .hit(hit)
);

// File: tb/dram_cmd_gen_tb.sv
module dram_cmd_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, cmd_ready = 1'b0, use_close = 1'b0;
  logic [13:0] req_row = '0;
  logic [9:0]  req_col = '0;

  logic        o_rr, o_cv, o_hv, o_h, c_rr, c_cv, c_hv, c_h;
  logic [1:0]  o_ct, c_ct, o_rid, c_rid;
  logic [2:0]  o_bk, c_bk;
  logic [13:0] o_ad, c_ad;

  dram_cmd_gen #(.BANK_ID(5), .REQ_ID(2), .OPEN_ROW(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid && !use_close), .req_ready(o_rr),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .cmd_valid(o_cv), .cmd_ready(cmd_ready && !use_close), .cmd_type(o_ct),
    .cmd_bank(o_bk), .cmd_addr(o_ad), .cmd_rid(o_rid), .hit_valid(o_hv), .hit(o_h));

  dram_cmd_gen #(.BANK_ID(1), .REQ_ID(3), .OPEN_ROW(1'b0)) dut_close_i (
    .clk(clk), .rst(rst), .req_valid(req_valid && use_close), .req_ready(c_rr),
    .req_write(req_write), .req_row(req_row), .req_col(req_col),
    .cmd_valid(c_cv), .cmd_ready(cmd_ready && use_close), .cmd_type(c_ct),
    .cmd_bank(c_bk), .cmd_addr(c_ad), .cmd_rid(c_rid), .hit_valid(c_hv), .hit(c_h));

  wire        rr  = use_close ? c_rr : o_rr;
  wire        cv  = use_close ? c_cv : o_cv;
  wire        hv  = use_close ? c_hv : o_hv;
  wire        h   = use_close ? c_h  : o_h;
  wire [1:0]  ct  = use_close ? c_ct : o_ct;
  wire [1:0]  rid = use_close ? c_rid : o_rid;
  wire [2:0]  bk  = use_close ? c_bk : o_bk;
  wire [13:0] ad  = use_close ? c_ad : o_ad;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One request; expected commands in t0..t2 / a0..a2, n of them.
  task automatic send(input bit wr, input int row, input int col, input int n,
                      input int t0, input int a0, input int t1, input int a1,
                      input int t2, input int a2, input bit ehit, input bit stall,
                      input string tag);
    int et, ea;
    @(negedge clk);
    req_write = wr; req_row = 14'(row); req_col = 10'(col); req_valid = 1'b1;
    chk(rr == 1'b1, {tag, " R8 ready before accept"}, rr, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(hv == 1'b1, {tag, " R9 hit_valid"}, hv, 1);
    chk(h == ehit, {tag, " R9 hit flag"}, h, ehit);
    for (int k = 0; k < n; k++) begin
      et = (k == 0) ? t0 : (k == 1) ? t1 : t2;
      ea = (k == 0) ? a0 : (k == 1) ? a1 : a2;
      chk(cv == 1'b1, {tag, " R8 cmd_valid"}, cv, 1);
      chk(int'(ct) == et, {tag, " R7 cmd_type"}, ct, et);
      chk(int'(ad) == ea, {tag, " R7 cmd_addr"}, ad, ea);
      chk(int'(bk) == (use_close ? 1 : 5), {tag, " R7 cmd_bank"}, bk, use_close ? 1 : 5);
      chk(int'(rid) == (use_close ? 3 : 2), {tag, " R7 cmd_rid"}, rid, use_close ? 3 : 2);
      chk(rr == 1'b0, {tag, " R8 busy"}, rr, 0);
      if (k == 0) begin
        @(posedge clk); @(negedge clk);
        chk(hv == 1'b0, {tag, " R9 single pulse"}, hv, 0);
      end
      if (stall && k == 1) begin
        cmd_ready = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(cv == 1'b1 && int'(ct) == et && int'(ad) == ea, {tag, " R8 hold"}, ad, ea);
      end
      cmd_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_ready = 1'b0;
    end
    chk(cv == 1'b0, {tag, " R8 done"}, cv, 0);
    chk(rr == 1'b1, {tag, " R8 ready again"}, rr, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(o_cv == 0 && c_cv == 0, "R1 cmd_valid", o_cv, 0);
    chk(o_hv == 0 && c_hv == 0, "R1 hit_valid", o_hv, 0);
    chk(o_rr == 1 && c_rr == 1, "R1 req_ready", o_rr, 1);
  endtask

  task automatic t_open_seq();
    use_close = 1'b0;
    send(0, 5, 3, 2, 1, 5, 2, 3, 0, 0, 0, 0, "R2 empty read");
    send(1, 5, 7, 1, 3, 7, 0, 0, 0, 0, 1, 0, "R3 R10 R5 hit write");
    send(0, 9, 1, 3, 0, 5, 1, 9, 2, 1, 0, 1, "R4 miss with stall");
    send(0, 9, 2, 1, 2, 2, 0, 0, 0, 0, 1, 0, "R5 row kept");
    send(1, 9, 1023, 1, 3, 1023, 0, 0, 0, 0, 1, 0, "R10 write max col");
  endtask

  task automatic t_close_seq();
    use_close = 1'b1;
    send(0, 4, 0, 2, 1, 4, 2, 0, 0, 0, 0, 0, "R6 close first");
    send(1, 4, 6, 2, 1, 4, 3, 6, 0, 0, 0, 0, "R6 close same row");
    send(0, 16383, 9, 2, 1, 16383, 2, 9, 0, 0, 0, 0, "R6 close new row");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_open_seq();
    t_close_seq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule